// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This unit compares two IEEE-754 operands, either both single precision or both double precision, and writes the outcome as a two-bit condition code. The code goes into one of four condition fields of a 64-bit floating-point status word. The caller provides the current status word together with the operands and a start strobe. One cycle later the unit returns the updated status word, a done strobe and, if one applies, a trap request.

There are two variants of the compare. The quiet variant only looks at the result of the ordering. The signaling variant first checks the operands for a NaN of either kind. In both variants the invalid trap-enable bit decides what an unordered outcome does. If the bit is set, the unit raises a trap and records the current invalid flag. If the bit is clear, the unit writes the unordered code and sets the accrued invalid flag.

Top module: `fcmp_cond_unit`

## Requirements
- R1: For ordered operands, the selected field receives 2'b00 when the operands are equal, 2'b01 when A is less than B, and 2'b10 when A is greater than B. The ordering follows the sign and magnitude of the encodings.
- R2: Select 0 addresses status bits 11:10. Selects 1, 2 and 3 address bits 33:32, 35:34 and 37:36, which sit 22, 24 and 26 bits above bits 11:10.
- R3: Every status bit outside the selected field, the trap-type field, the current invalid bit 4 and the accrued invalid bit 9 is passed through from status_i unchanged.
- R4: Each compare clears the trap-type field, status bits 16:14. When no trap is raised, the field stays 3'b000.
- R5: When either operand is a NaN and the invalid trap-enable bit 27 is clear, the selected field becomes 2'b11, bit 9 is set and trap_o stays low.
- R6: When the outcome is unordered and bit 27 is set, trap_o is raised, bit 4 is set, the trap-type field becomes 3'b001 and the selected field keeps its old value. This holds in both variants.
- R7: In the signaling variant (signal_i=1), a NaN of either kind in either operand with bit 27 set gives the same trap response as R6.
- R8: +0 and -0 compare equal. +infinity is greater than every finite value and -infinity is less than every finite value.
- R9: With dbl_i=0, the operands are taken from bits 31:0 of each input. Bits 63:32 have no effect on the result.
- R10: done_o pulses exactly one cycle after start_i. status_o and trap_o are valid in that cycle, and trap_o is never high without done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a compare in this cycle |
| dbl_i | input | 1 | 1: double precision, 0: single precision |
| signal_i | input | 1 | 1: signaling variant, 0: quiet variant |
| fsel_i | input | 2 | Selects the condition field |
| op_a_i | input | 64 | Operand A |
| op_b_i | input | 64 | Operand B |
| status_i | input | 64 | Current status word |
| status_o | output | 64 | Updated status word, valid with done_o |
| trap_o | output | 1 | Trap request, valid with done_o |
| done_o | output | 1 | Result strobe |

## Verification
The bench sends every pairing of finite values, signed zeros, infinities, quiet NaNs and signaling NaNs through every field select, both precisions, both variants and both trap-enable settings. Each run starts from a random status word that has stale trap-type bits in it. A design that compared the raw encodings as integers would order negative numbers the wrong way round and would report -0 as less than +0. A design that decoded the field select wrongly, or masked the field wrongly, would clobber a neighbouring field, and the pass-through check on the whole word catches that. Single-precision operands carry unrelated upper halves, so a design that looked at the wrong half would give wrong codes. A design that wrote the condition code on a trap, or left the stale trap type in place, would fail the trap-path comparison.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int OP_W     = 64;
  localparam int MAG_W    = OP_W - 1;
  localparam int SP_EXP   = 8;
  localparam int SP_MAN   = 23;
  localparam int DP_EXP   = 11;
  localparam int DP_MAN   = 52;

  localparam int FCC_BASE = 10;
  localparam int TT_LSB   = 14;
  localparam int TT_W     = 3;
  localparam int NVM_BIT  = 27;
  localparam int NVA_BIT  = 9;
  localparam int NVC_BIT  = 4;
  localparam logic [TT_W-1:0] TT_IEEE = 3'd1;

  typedef enum logic [1:0] {
    REL_EQ = 2'b00,
    REL_LT = 2'b01,
    REL_GT = 2'b10,
    REL_UN = 2'b11
  } rel_e;

  typedef struct packed {
    logic             sign;
    logic             nan;
    logic             zero;
    logic [MAG_W-1:0] mag;
  } opnd_t;

  // bit position of condition field f; higher fields are offset 22/24/26
  function automatic int fcc_pos(input int f);
    return (f == 0) ? FCC_BASE : FCC_BASE + 20 + 2 * f;
  endfunction
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic            dbl_i,
  output opnd_t           res_o
);
  opnd_t cls [2];

  for (genvar p = 0; p < 2; p++) begin : g_prec
    localparam int EW = (p == 1) ? DP_EXP : SP_EXP;
    localparam int MW = (p == 1) ? DP_MAN : SP_MAN;
    localparam int SB = EW + MW;
    logic [EW-1:0] exp_f;
    logic [MW-1:0] man_f;
    assign exp_f = op_i[SB-1:MW];
    assign man_f = op_i[MW-1:0];
    assign cls[p].sign = op_i[SB];
    assign cls[p].nan  = (&exp_f) & (|man_f);
    assign cls[p].zero = ~(|exp_f) & ~(|man_f);
    assign cls[p].mag  = MAG_W'(op_i[SB-1:0]);
  end

  assign res_o = dbl_i ? cls[1] : cls[0];
endmodule

// File: rtl/fcmp_relate.sv
module fcmp_relate
  import fcmp_pkg::*;
(
  input  opnd_t a_i,
  input  opnd_t b_i,
  output rel_e  rel_o
);
  logic mag_lt, mag_eq;
  assign mag_lt = a_i.mag < b_i.mag;
  assign mag_eq = a_i.mag == b_i.mag;

  always_comb begin
    if (a_i.nan || b_i.nan)          rel_o = REL_UN;
    else if (a_i.zero && b_i.zero)   rel_o = REL_EQ;
    else if (a_i.sign != b_i.sign)   rel_o = a_i.sign ? REL_LT : REL_GT;
    else if (mag_eq)                 rel_o = REL_EQ;
    else if (!a_i.sign)              rel_o = mag_lt ? REL_LT : REL_GT;
    else                             rel_o = mag_lt ? REL_GT : REL_LT;
  end
endmodule

// File: rtl/fcmp_stat_upd.sv
module fcmp_stat_upd
  import fcmp_pkg::*;
#(
  parameter int STAT_W   = 64,
  parameter int N_FIELDS = 4,
  localparam int FS_W    = $clog2(N_FIELDS)
) (
  input  logic [STAT_W-1:0] status_i,
  input  rel_e              rel_i,
  input  logic              nan_any_i,
  input  logic              signal_i,
  input  logic [FS_W-1:0]   fsel_i,
  output logic [STAT_W-1:0] status_o,
  output logic              trap_o
);
  logic [STAT_W-1:0] sel_mask [N_FIELDS];
  logic [STAT_W-1:0] code_val [N_FIELDS];

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
    localparam int POS = fcc_pos(g);
    logic hit;
    assign hit         = fsel_i == FS_W'(g);
    assign sel_mask[g] = hit ? (STAT_W'(2'b11) << POS) : '0;
    assign code_val[g] = hit ? (STAT_W'(rel_i) << POS) : '0;
  end

  logic trap_en, sig_trap, un_trap;
  assign trap_en  = status_i[NVM_BIT];
  assign sig_trap = signal_i & nan_any_i & trap_en;
  assign un_trap  = (rel_i == REL_UN) & trap_en;

  always_comb begin
    logic [STAT_W-1:0] m, c;
    m = '0;
    c = '0;
    for (int i = 0; i < N_FIELDS; i++) begin
      m = m | sel_mask[i];
      c = c | code_val[i];
    end
    status_o = status_i;
    status_o[TT_LSB +: TT_W] = '0;
    trap_o = sig_trap | un_trap;
    if (trap_o) begin
      status_o[NVC_BIT] = 1'b1;
      status_o[TT_LSB +: TT_W] = TT_IEEE;
    end else begin
      status_o = (status_o & ~m) | c;
      if (rel_i == REL_UN) status_o[NVA_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/fcmp_cond_unit.sv
module fcmp_cond_unit
  import fcmp_pkg::*;
#(
  parameter int STAT_W   = 64,
  parameter int N_FIELDS = 4,
  localparam int FS_W    = $clog2(N_FIELDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dbl_i,
  input  logic              signal_i,
  input  logic [FS_W-1:0]   fsel_i,
  input  logic [OP_W-1:0]   op_a_i,
  input  logic [OP_W-1:0]   op_b_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [STAT_W-1:0] status_o,
  output logic              trap_o,
  output logic              done_o
);
  opnd_t a_c, b_c;
  rel_e  rel_c;
  logic [STAT_W-1:0] status_c;
  logic trap_c;

  fcmp_classify u_cls_a (.op_i(op_a_i), .dbl_i(dbl_i), .res_o(a_c));
  fcmp_classify u_cls_b (.op_i(op_b_i), .dbl_i(dbl_i), .res_o(b_c));
  fcmp_relate   u_rel   (.a_i(a_c), .b_i(b_c), .rel_o(rel_c));

  fcmp_stat_upd #(.STAT_W(STAT_W), .N_FIELDS(N_FIELDS)) u_upd (
    .status_i (status_i),
    .rel_i    (rel_c),
    .nan_any_i(a_c.nan | b_c.nan),
    .signal_i (signal_i),
    .fsel_i   (fsel_i),
    .status_o (status_c),
    .trap_o   (trap_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      trap_o   <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= start_i;
      trap_o <= start_i & trap_c;
      if (start_i) status_o <= status_c;
    end
  end
endmodule

// File: rtl/fcmp_cond_unit_chk.sv
module fcmp_cond_unit_chk
  import fcmp_pkg::*;
#(
  parameter int STAT_W   = 64,
  parameter int N_FIELDS = 4,
  localparam int FS_W    = $clog2(N_FIELDS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              dbl_i,
  input logic              signal_i,
  input logic [FS_W-1:0]   fsel_i,
  input logic [OP_W-1:0]   op_a_i,
  input logic [OP_W-1:0]   op_b_i,
  input logic [STAT_W-1:0] status_i,
  input logic [STAT_W-1:0] status_o,
  input logic              trap_o,
  input logic              done_o
);
  function automatic logic [STAT_W-1:0] writable(input logic [FS_W-1:0] f);
    logic [STAT_W-1:0] m;
    m = '0;
    m[TT_LSB +: TT_W] = '1;
    m[NVC_BIT] = 1'b1;
    m[NVA_BIT] = 1'b1;
    m[fcc_pos(int'(f)) +: 2] = 2'b11;
    return m;
  endfunction

  function automatic logic [1:0] fld(input logic [STAT_W-1:0] s, input logic [FS_W-1:0] f);
    return s[fcc_pos(int'(f)) +: 2];
  endfunction

  a_r10_done_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  a_r10_done_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i));
  a_r10_trap_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> done_o);
  a_r6_trap_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (status_o[TT_LSB +: TT_W] == TT_IEEE) && status_o[NVC_BIT]);
  a_r4_tt_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !trap_o) |-> (status_o[TT_LSB +: TT_W] == '0));
  a_r3_others_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (((status_o ^ $past(status_i)) & ~writable($past(fsel_i))) == '0));
  a_r6_no_trap_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(status_i[NVM_BIT])) |-> !trap_o);
  a_r6_field_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (fld(status_o, $past(fsel_i)) == fld($past(status_i), $past(fsel_i))));
endmodule

bind fcmp_cond_unit fcmp_cond_unit_chk #(.STAT_W(STAT_W), .N_FIELDS(N_FIELDS)) u_chk (.*);

// File: tb/fcmp_cond_unit_test.sv
module fcmp_cond_unit_test;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        start_i = 0;
  logic        dbl_i = 0;
  logic        signal_i = 0;
  logic [1:0]  fsel_i = 0;
  logic [63:0] op_a_i = 0, op_b_i = 0, status_i = 0;
  logic [63:0] status_o;
  logic        trap_o, done_o;

  int total = 0, bad = 0;
  bit finished = 0;

  fcmp_cond_unit uut (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input bit dbl, input int i);
    logic [63:0] v;
    case (i)
      0: v = dbl ? 64'h3FF0000000000000 : 64'h3F800000;  // 1.0
      1: v = dbl ? 64'h4000000000000000 : 64'h40000000;  // 2.0
      2: v = dbl ? 64'hBFF0000000000000 : 64'hBF800000;  // -1.0
      3: v = dbl ? 64'hC000000000000000 : 64'hC0000000;  // -2.0
      4: v = 64'h0;                                      // +0
      5: v = dbl ? 64'h8000000000000000 : 64'h80000000;  // -0
      6: v = dbl ? 64'h7FF0000000000000 : 64'h7F800000;  // +inf
      7: v = dbl ? 64'hFFF0000000000000 : 64'hFF800000;  // -inf
      8: v = dbl ? 64'h7FF8000000000000 : 64'h7FC00000;  // qNaN
      default: v = dbl ? 64'hFFF0000000000001 : 64'hFF800001; // sNaN
    endcase
    if (!dbl) v[63:32] = $urandom(); // R9: upper half is noise
    return v;
  endfunction

  function automatic bit is_nan(input logic [63:0] v, input bit dbl);
    return dbl ? (v[62:52] == 11'h7FF && v[51:0] != 0) : (v[30:23] == 8'hFF && v[22:0] != 0);
  endfunction

  function automatic longint key(input logic [63:0] v, input bit dbl);
    longint m;
    m = dbl ? longint'(v[62:0]) : longint'(v[30:0]);
    return (dbl ? v[63] : v[31]) ? -m : m;
  endfunction

  task automatic ref_cmp(input logic [63:0] a, b, input bit dbl, input logic [1:0] fs,
                         input logic [63:0] st, output logic [63:0] est, output bit etrap);
    int pos;
    longint ka, kb;
    pos = (fs == 0) ? 10 : 30 + 2 * int'(fs);
    est = st;
    est[16:14] = 3'b000;
    etrap = 0;
    if (is_nan(a, dbl) || is_nan(b, dbl)) begin
      if (st[27]) begin
        etrap = 1;
        est[4] = 1'b1;
        est[16:14] = 3'b001;
      end else begin
        est[pos +: 2] = 2'b11;
        est[9] = 1'b1;
      end
    end else begin
      ka = key(a, dbl);
      kb = key(b, dbl);
      est[pos +: 2] = (ka == kb) ? 2'b00 : (ka < kb) ? 2'b01 : 2'b10;
    end
  endtask

  task automatic run_cmp(input logic [63:0] a, b, input bit dbl, sig, input logic [1:0] fs,
                         input logic [63:0] st, input string tag);
    logic [63:0] est;
    bit etrap;
    int pos;
    ref_cmp(a, b, dbl, fs, st, est, etrap);
    pos = (fs == 0) ? 10 : 30 + 2 * int'(fs);
    op_a_i = a; op_b_i = b; dbl_i = dbl; signal_i = sig; fsel_i = fs; status_i = st;
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    chk64("R10 done", {63'b0, done_o}, 64'd1);
    chk64({tag, " trap"}, {63'b0, trap_o}, {63'b0, etrap});
    chk64({tag, " field"}, {62'b0, status_o[pos +: 2]}, {62'b0, est[pos +: 2]});
    chk64("R4 trap type", {61'b0, status_o[16:14]}, {61'b0, est[16:14]});
    chk64("R3 status word", status_o, est);
  endtask

  initial begin
    logic [63:0] st, a, b;
    string t;
    repeat (3) @(negedge clk_i);
    chk64("R10 reset done", {63'b0, done_o}, 64'd0);
    chk64("R10 reset trap", {63'b0, trap_o}, 64'd0);
    chk64("R10 reset status", status_o, 64'd0);
    rst_ni = 1;
    @(negedge clk_i);

    // R2: field 2 of a zero word, 1.0 < 2.0 sets only bit 34
    run_cmp(64'h3F800000, 64'h40000000, 0, 0, 2'd2, 64'h0, "R2");
    chk64("R2 exact bit", status_o, 64'h0000_0004_0000_0000);
    // R9: upper halves differ, single compare still sees 1.0 < 2.0
    run_cmp(64'hFFFFFFFF_3F800000, 64'h00000000_40000000, 0, 0, 2'd0, 64'h0, "R9");
    chk64("R9 single ignores upper", {62'b0, status_o[11:10]}, 64'd1);

    for (int fs = 0; fs < 4; fs++) begin
      for (int d = 0; d < 2; d++) begin
        for (int ia = 0; ia < 10; ia++) begin
          for (int ib = 0; ib < 10; ib++) begin
            for (int v = 0; v < 4; v++) begin
              a = pat(d[0], ia);
              b = pat(d[0], ib);
              st = {$urandom(), $urandom()};
              st[27] = v[0];
              if (is_nan(a, d[0]) || is_nan(b, d[0]))
                t = v[0] ? (v[1] ? "R7" : "R6") : "R5";
              else if (ia >= 4)
                t = "R8";
              else
                t = "R1";
              if (d == 0) t = {t, "/R9"};
              run_cmp(a, b, d[0], v[1], fs[1:0], st, t);
            end
          end
        end
        @(negedge clk_i);
        chk64("R10 idle done", {63'b0, done_o}, 64'd0);
      end
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R10 watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule